// File: doc/BRIEF.md
# Sideband-Framed I2C Packet Receiver

This block is a write-only I2C target that collects fixed-length packets from an external I2C controller. The two bus lines are brought into the system clock domain through synchroniser flops and sampled at a rate of at least eight times the SCL rate. The block finds START and STOP conditions and compares the first byte of a transfer with its own address. When the address matches, it acknowledges the address and every data byte by pulling SDA low through an open-drain enable, and it stores the data bytes in a packet buffer.

The end of a packet is not taken from STOP. The controller raises a separate interrupt line some time before it begins a transfer and drops that line as soon as the last data byte has gone out. On that falling edge the block checks that the address matched and that exactly the configured number of bytes arrived. If both hold, it presents the packet on a valid/ready output. If either fails, it gives a one-cycle error pulse. The output follows stream rules. Once `pkt_valid` is high, it stays high and `pkt_data` stays unchanged until a cycle in which `pkt_ready` is also high. That cycle is the transfer, and `pkt_valid` drops on the next edge. If the consumer holds `pkt_ready` low, the pending packet is kept, and a further completed packet that arrives meanwhile is rejected as an error.

Top module: `i2c_pkt_rx`

## Requirements
- R1: After reset, `pkt_valid`, `pkt_err` and `sda_oe` are all low.
- R2: Only the address byte 0x32 is acknowledged, that is 7-bit address 0x19 with the R/W bit (bit 0) low. Acknowledging means `sda_oe` is high during the 9th SCL pulse. Any other address byte, including 0x33 and 0x34, gets no acknowledge, and the rest of that transfer is ignored, so no data byte of it is acknowledged either.
- R3: In a matched transfer, every data byte is acknowledged on its 9th SCL pulse. Bits are sampled on SCL rising edges, most significant bit first.
- R4: `sda_oe` changes only while SCL is low, so it holds one value over a whole SCL high phase.
- R5: When the interrupt line falls after a matched transfer of exactly 9 data bytes, `pkt_valid` rises. The first byte received sits in `pkt_data[7:0]`, and byte k sits in `pkt_data[8k+7:8k]`.
- R6: When the interrupt line falls and the byte count is not 9, or no address match took place, `pkt_err` pulses high for exactly one cycle and `pkt_valid` stays low.
- R7: While `pkt_valid` is high and `pkt_ready` is low, `pkt_valid` stays high and `pkt_data` stays stable. After a cycle in which both are high, `pkt_valid` is low.
- R8: A START, including a repeated START, clears the byte count. After a repeated START, only the bytes that follow it form the packet.
- R9: If the interrupt line falls while an earlier packet is still pending, `pkt_err` pulses, and the pending packet stays on `pkt_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | High pulls SDA low (open-drain acknowledge) |
| int_i | input | 1 | Packet-framing interrupt line from the controller |
| pkt_valid | output | 1 | Complete packet present on pkt_data |
| pkt_ready | input | 1 | Consumer accepts the packet |
| pkt_data | output | PKT_BYTES*8 | Packet bytes, first byte in the low bits |
| pkt_err | output | 1 | One-cycle pulse on a rejected packet |

## Verification
Every pin reaches the logic through two synchroniser flops, and every result is registered once more. An edge on SCL, SDA or the interrupt line therefore shows up on `sda_oe`, `pkt_valid` or `pkt_err` three clock edges later. The bench drives inputs on falling clock edges and waits at least six cycles before it samples an output. It reads the acknowledge three cycles after SCL rises and again just before SCL falls, so it checks both the value and the stability across the high phase. Because `pkt_err` lasts a single cycle, a monitor counts its pulses on every falling clock edge, and each scenario compares that count with the number it expects.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_ADDR,
    RX_DATA,
    RX_ACK,
    RX_SKIP
  } rx_state_e;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic prev
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= {(STAGES+1){RST_VAL}};
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign lvl  = sh[STAGES-1];
  assign prev = sh[STAGES];
endmodule

// File: rtl/i2c_byte_rx.sv
module i2c_byte_rx import pkt_rx_pkg::*; #(
  parameter logic [6:0] DEV_ADDR = 7'h19
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_lvl,
  input  logic       start_ev,
  input  logic       stop_ev,
  output logic       sda_oe,
  output logic       addr_hit,
  output logic       byte_stb,
  output logic [7:0] byte_val
);
  localparam logic [7:0] ADDR_BYTE = {DEV_ADDR, 1'b0};

  rx_state_e  state;
  logic [2:0] bit_cnt;
  logic [7:0] shreg;
  logic [7:0] next_sh;
  logic       ack_drv;
  logic       hit;

  assign next_sh = {shreg[6:0], sda_lvl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      ack_drv  <= 1'b0;
      hit      <= 1'b0;
      byte_stb <= 1'b0;
    end else begin
      byte_stb <= 1'b0;
      if (start_ev) begin
        state   <= RX_ADDR;
        bit_cnt <= '0;
        ack_drv <= 1'b0;
        hit     <= 1'b0;
      end else if (stop_ev) begin
        state   <= RX_IDLE;
        ack_drv <= 1'b0;
      end else begin
        case (state)
          RX_ADDR, RX_DATA: begin
            if (scl_rise) begin
              shreg   <= next_sh;
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) begin
                if (state == RX_ADDR) begin
                  if (next_sh == ADDR_BYTE) begin
                    hit   <= 1'b1;
                    state <= RX_ACK;
                  end else begin
                    state <= RX_SKIP;
                  end
                end else begin
                  byte_stb <= 1'b1;
                  state    <= RX_ACK;
                end
              end
            end
          end
          RX_ACK: begin
            if (scl_fall) begin
              if (!ack_drv) begin
                ack_drv <= 1'b1;
              end else begin
                ack_drv <= 1'b0;
                bit_cnt <= '0;
                state   <= RX_DATA;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe   = ack_drv;
  assign addr_hit = hit;
  assign byte_val = shreg;

  // R4
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ack_drv) |-> !scl_lvl);
  // R2
  ack_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_drv |-> hit);
endmodule

// File: rtl/pkt_store.sv
module pkt_store #(
  parameter int NBYTES = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              byte_stb,
  input  logic [7:0]        byte_val,
  input  logic              addr_hit,
  input  logic              frame_end,
  input  logic              ready,
  output logic              valid,
  output logic [NBYTES*8-1:0] data,
  output logic              err
);
  localparam int CW = $clog2(NBYTES + 2);
  localparam logic [CW-1:0] FULL = CW'(NBYTES);
  localparam logic [CW-1:0] OVER = CW'(NBYTES + 1);

  logic [CW-1:0] cnt;
  logic [7:0]    slot [NBYTES];
  logic          busy;

  assign busy = valid && !ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt <= '0;
    else if (clear)                     cnt <= '0;
    else if (byte_stb && cnt != OVER)   cnt <= cnt + 1'b1;
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             slot[g] <= '0;
      else if (byte_stb && cnt == CW'(g))     slot[g] <= byte_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      err   <= 1'b0;
    end else begin
      err <= 1'b0;
      if (valid && ready) valid <= 1'b0;
      if (frame_end) begin
        if (cnt == FULL && addr_hit && !busy) begin
          valid <= 1'b1;
          for (int i = 0; i < NBYTES; i++) data[i*8 +: 8] <= slot[i];
        end else begin
          err <= 1'b1;
        end
      end
    end
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(data)));
  // R6
  err_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
  // R5
  full_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> ($past(cnt) == FULL));
endmodule

// File: rtl/i2c_pkt_rx.sv
module i2c_pkt_rx #(
  parameter logic [6:0] DEV_ADDR    = 7'h19,
  parameter int         PKT_BYTES   = 9,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe,
  input  logic                   int_i,
  output logic                   pkt_valid,
  input  logic                   pkt_ready,
  output logic [PKT_BYTES*8-1:0] pkt_data,
  output logic                   pkt_err
);
  localparam int          NLINES   = 3;
  localparam logic [2:0]  IDLE_LVL = 3'b011;

  logic [NLINES-1:0] raw, lvl, prev;
  assign raw = {int_i, sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_LVL[g])) u_sync (
      .clk (clk), .rst_n (rst_n), .din (raw[g]), .lvl (lvl[g]), .prev (prev[g])
    );
  end

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev, int_fall;
  assign scl_lvl  = lvl[0];
  assign sda_lvl  = lvl[1];
  assign scl_rise = lvl[0] & ~prev[0];
  assign scl_fall = ~lvl[0] & prev[0];
  assign start_ev = lvl[0] & prev[0] & prev[1] & ~lvl[1];
  assign stop_ev  = lvl[0] & prev[0] & ~prev[1] & lvl[1];
  assign int_fall = prev[2] & ~lvl[2];

  logic       addr_hit, byte_stb;
  logic [7:0] byte_val;

  i2c_byte_rx #(.DEV_ADDR(DEV_ADDR)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_lvl  (scl_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_lvl  (sda_lvl),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .sda_oe   (sda_oe),
    .addr_hit (addr_hit),
    .byte_stb (byte_stb),
    .byte_val (byte_val)
  );

  pkt_store #(.NBYTES(PKT_BYTES)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_ev),
    .byte_stb  (byte_stb),
    .byte_val  (byte_val),
    .addr_hit  (addr_hit),
    .frame_end (int_fall),
    .ready     (pkt_ready),
    .valid     (pkt_valid),
    .data      (pkt_data),
    .err       (pkt_err)
  );
endmodule

// File: tb/test_i2c_pkt_rx.sv
module test_i2c_pkt_rx;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 20;
  localparam int NB = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, int_i = 1'b0, pkt_ready = 1'b0;
  logic sda_oe, pkt_valid, pkt_err;
  logic [NB*8-1:0] pkt_data;
  logic sda_line;
  int n_chk = 0, n_fail = 0, err_seen = 0;

  assign sda_line = m_sda & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_pkt_rx i_i2c_pkt_rx (
    .clk (clk), .rst_n (rst_n), .scl_i (m_scl), .sda_i (sda_line),
    .sda_oe (sda_oe), .int_i (int_i), .pkt_valid (pkt_valid),
    .pkt_ready (pkt_ready), .pkt_data (pkt_data), .pkt_err (pkt_err)
  );

  always @(negedge clk) if (pkt_err) err_seen++;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NB*8-1:0] exp_pkt(input logic [7:0] seed);
    logic [NB*8-1:0] v;
    for (int i = 0; i < NB; i++) v[i*8 +: 8] = seed + 8'(i * 37);
    return v;
  endfunction

  task automatic i2c_start();
    m_sda = 1'b1; wait_clk(HP);
    m_scl = 1'b1; wait_clk(HP);
    m_sda = 1'b0; wait_clk(HP);
    m_scl = 1'b0; wait_clk(HP);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wait_clk(HP);
    m_scl = 1'b1; wait_clk(HP);
    m_sda = 1'b1; wait_clk(HP);
  endtask

  task automatic i2c_byte(input logic [7:0] b, output bit acked, output bit steady);
    logic first;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wait_clk(HP);
      m_scl = 1'b1; wait_clk(HP);
      m_scl = 1'b0;
    end
    m_sda = 1'b1; wait_clk(HP);
    m_scl = 1'b1; wait_clk(3);
    first = sda_oe;
    wait_clk(HP - 6);
    acked  = !sda_line;
    steady = (first == sda_oe);
    wait_clk(3);
    m_scl = 1'b0;
  endtask

  task automatic send_bytes(input logic [7:0] seed, input int n, input bit exp_ack, input string req);
    bit a, s;
    for (int i = 0; i < n; i++) begin
      i2c_byte(seed + 8'(i * 37), a, s);
      chk(a == exp_ack, req, a, exp_ack);
      chk(s, "R4", s, 1);
    end
  endtask

  task automatic xfer(input logic [7:0] abyte, input logic [7:0] seed, input int n, input bit exp_ack);
    bit a, s;
    int_i = 1'b1; wait_clk(100);
    i2c_start();
    i2c_byte(abyte, a, s);
    chk(a == exp_ack, "R2", a, exp_ack);
    chk(s, "R4", s, 1);
    send_bytes(seed, n, exp_ack, exp_ack ? "R3" : "R2");
    i2c_stop();
    err_seen = 0;
    int_i = 1'b0; wait_clk(8);
  endtask

  task automatic test_reset();
    chk(!pkt_valid && !pkt_err && !sda_oe, "R1", {pkt_valid, pkt_err, sda_oe}, 0);
  endtask

  task automatic test_good_and_hold();
    xfer(8'h32, 8'h5A, NB, 1'b1);
    chk(pkt_valid, "R5", pkt_valid, 1);
    chk(pkt_data == exp_pkt(8'h5A), "R5", pkt_data, exp_pkt(8'h5A));
    chk(err_seen == 0, "R5", err_seen, 0);
    wait_clk(30);
    chk(pkt_valid && pkt_data == exp_pkt(8'h5A), "R7", pkt_data, exp_pkt(8'h5A));
    pkt_ready = 1'b1; wait_clk(1);
    pkt_ready = 1'b0;
    chk(!pkt_valid, "R7", pkt_valid, 0);
  endtask

  task automatic test_reject(input logic [7:0] abyte, input int n, input bit exp_ack, input string req);
    xfer(abyte, 8'h11, n, exp_ack);
    chk(err_seen == 1, req, err_seen, 1);
    chk(!pkt_valid, req, pkt_valid, 0);
  endtask

  task automatic test_restart();
    bit a, s;
    int_i = 1'b1; wait_clk(100);
    i2c_start();
    i2c_byte(8'h32, a, s);
    send_bytes(8'h80, 4, 1'b1, "R8");
    i2c_start();
    i2c_byte(8'h32, a, s);
    chk(a, "R8", a, 1);
    send_bytes(8'hC3, NB, 1'b1, "R8");
    i2c_stop();
    err_seen = 0;
    int_i = 1'b0; wait_clk(8);
    chk(pkt_valid && err_seen == 0, "R8", {pkt_valid, 8'(err_seen)}, 9'h100);
    chk(pkt_data == exp_pkt(8'hC3), "R8", pkt_data, exp_pkt(8'hC3));
    pkt_ready = 1'b1; wait_clk(1); pkt_ready = 1'b0; wait_clk(2);
  endtask

  task automatic test_overrun();
    xfer(8'h32, 8'h27, NB, 1'b1);
    chk(pkt_valid, "R9", pkt_valid, 1);
    xfer(8'h32, 8'hE1, NB, 1'b1);
    chk(err_seen == 1, "R9", err_seen, 1);
    chk(pkt_valid && pkt_data == exp_pkt(8'h27), "R9", pkt_data, exp_pkt(8'h27));
    pkt_ready = 1'b1; wait_clk(1); pkt_ready = 1'b0;
    chk(!pkt_valid, "R7", pkt_valid, 0);
  endtask

  initial begin
    wait_clk(5);
    test_reset();
    rst_n = 1'b1;
    wait_clk(5);
    test_reset();
    test_good_and_hold();
    test_reject(8'h34, NB, 1'b0, "R6");
    test_reject(8'h33, NB, 1'b0, "R2");
    test_reject(8'h32, NB - 1, 1'b1, "R6");
    test_reject(8'h32, NB + 1, 1'b1, "R6");
    test_restart();
    test_overrun();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule